// File: doc/BRIEF.md
# Periodic Real-Time Tick Interrupt Generator

This block divides the bus clock into a periodic tick. The tick period is a base count of bus cycles scaled by a power of two, and a two-bit rate field in a control register picks the power. Each tick raises a sticky pending flag. Software clears the flag by writing a one to its bit. A registered interrupt request is raised while the flag and a separate enable bit are both set.

The tick schedule is anchored to the time of the last tick. When the rate field is rewritten, the period is not restarted. The next tick lands at the last tick time plus the new period. If that time has already passed, the tick fires on the next cycle.

Software reaches the block through a byte-wide, write-only register bus with three decoded offsets: control, mask and flag. The pending flag and the interrupt request are brought out as outputs.

Top module: `rti_gen`

## Requirements
- R1: The tick period is BASE_PERIOD × 2^rate bus cycles (default 8192, 16384, 32768, 65536). The rate field is bits [1:0] of the control register at offset 0. The other control bits have no effect.
- R2: Each tick sets the pending flag, which is bit 6 of the flag register at offset 2 and is shown on `rti_pending` from the clock edge of the tick. After reset is released, the first tick comes BASE_PERIOD edges later.
- R3: Writing the control register does not set the flag and does not restart the period. The next tick falls at the last tick time plus the newly selected period.
- R4: A write to offset 2 with bit 6 set clears the flag at that edge. A write of zero to bit 6, including a write with every other bit set, leaves the flag unchanged.
- R5: The interrupt enable is bit 6 of the mask register at offset 1. While it is zero, `rti_irq` stays low whatever the flag does.
- R6: Reset clears the flag, the interrupt request, the enable and the rate field, and restarts the schedule from zero.
- R7: `rti_irq` is registered. It equals flag AND enable as they stood one clock earlier, so it rises one edge after both are set and falls one edge after either clears.
- R8: If a rate write makes the rescheduled tick time already past, the tick fires on the edge after the write edge.
- R9: When a clearing write and a tick fall on the same edge, the tick wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset (0 control, 1 mask, 2 flag) |
| bus_wdata | input | DATA_W | Register write data |
| rti_pending | output | 1 | Pending tick flag |
| rti_irq | output | 1 | Registered interrupt request |

## Verification
The bench measures tick intervals from one flag rise to the next, with a rate write placed one cycle after a tick. A design that restarted the period on a rate write would then measure one cycle long, and a wrong rate decode would give the wrong multiple. It rewrites the rate to a short period once the elapsed time already exceeds that period, which catches a design that compares for equality and misses the tick for a whole counter wrap. It also lands a clearing write exactly on a tick edge, where a design that gives priority to the clear would lose the tick. Separate checks cover writes of zero to the flag, the one-cycle lag of the interrupt behind its enable, and a reset in the middle of a slow period.

// File: rtl/rti_pkg.sv
package rti_pkg;
  // register offsets on the byte bus
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_MASK = 2'd1;
  localparam logic [1:0] OFS_FLAG = 2'd2;

  // bit positions inside the registers
  localparam int RATE_LSB = 0;
  localparam int ENA_BIT  = 6;
  localparam int FLAG_BIT = 6;

  // compute the counter width needed for the longest period
  function automatic int period_width(input int base, input int rate_w);
    return $clog2(base << ((1 << rate_w) - 1)) + 1;
  endfunction
endpackage

// File: rtl/rti_regs.sv
module rti_regs
  import rti_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate,
  output logic              irq_en,
  output logic              clr_req
);
  logic hit_ctrl, hit_mask, hit_flag;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
  assign hit_mask = wr_en && (wr_addr == ADDR_W'(OFS_MASK));
  assign hit_flag = wr_en && (wr_addr == ADDR_W'(OFS_FLAG));

  always_ff @(posedge clk) begin
    if (rst) begin
      rate   <= '0;
      irq_en <= 1'b0;
    end else begin
      if (hit_ctrl) rate   <= wr_data[RATE_LSB +: RATE_W];
      if (hit_mask) irq_en <= wr_data[ENA_BIT];
    end
  end

  // write-one-to-clear request, consumed by the flag stage
  assign clr_req = hit_flag && wr_data[FLAG_BIT];

  // rate only moves on a control write (R1)
  p_rate_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !hit_ctrl |=> $stable(rate));
  // enable only moves on a mask write (R5)
  p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !hit_mask |=> $stable(irq_en));
endmodule

// File: rtl/rti_divider.sv
module rti_divider
  import rti_pkg::*;
#(
  parameter int BASE_PERIOD = 8192,
  parameter int RATE_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int CNT_W     = period_width(BASE_PERIOD, RATE_W);
  localparam int MAX_PER   = BASE_PERIOD << (NUM_RATES - 1);

  logic [CNT_W-1:0] period_lut [NUM_RATES];
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] elapsed;

  // one period per rate code, each a doubling of the base
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_per
    assign period_lut[g] = CNT_W'(BASE_PERIOD) << g;
  end

  assign period = period_lut[rate];

  // cycles since the last tick; a rate change never resets it, so the
  // schedule stays anchored to the last tick, and the >= compare fires
  // at once when the new target already lies behind
  assign tick = (elapsed >= (period - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst)       elapsed <= '0;
    else if (tick) elapsed <= '0;
    else           elapsed <= elapsed + CNT_W'(1);
  end

  // the elapsed count never runs past the longest period (R1)
  p_bound_r1: assert property (@(posedge clk) disable iff (rst)
    elapsed <= CNT_W'(MAX_PER - 1));
  // without a tick the count keeps running across rate writes (R3)
  p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> elapsed == $past(elapsed) + CNT_W'(1));
endmodule

// File: rtl/rti_flag.sv
module rti_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr_req,
  input  logic irq_en,
  output logic pending,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      // a tick beats a clear landing on the same edge
      if (tick)         pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;
      irq <= pending && irq_en;
    end
  end

  p_tick_sets_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> pending);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !tick) |=> !pending);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && !tick) |=> $stable(pending));
  p_irq_lag_r7: assert property (@(posedge clk) disable iff (rst)
    (pending && irq_en) |=> irq);
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

// File: rtl/rti_gen.sv
module rti_gen
  import rti_pkg::*;
#(
  parameter int BASE_PERIOD = 8192,
  parameter int RATE_W      = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rti_pending,
  output logic              rti_irq
);
  logic [RATE_W-1:0] rate;
  logic              irq_en;
  logic              clr_req;
  logic              tick;

  rti_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .RATE_W(RATE_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_we),
    .wr_addr(bus_addr),
    .wr_data(bus_wdata),
    .rate   (rate),
    .irq_en (irq_en),
    .clr_req(clr_req)
  );

  rti_divider #(
    .BASE_PERIOD(BASE_PERIOD),
    .RATE_W     (RATE_W)
  ) u_div (
    .clk (clk),
    .rst (rst),
    .rate(rate),
    .tick(tick)
  );

  rti_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .clr_req(clr_req),
    .irq_en (irq_en),
    .pending(rti_pending),
    .irq    (rti_irq)
  );

  // a rate write alone never raises the flag (R3)
  p_write_no_set_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !rti_pending) |=> !rti_pending);
  // the request only follows a pending flag (R7)
  p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
    rti_irq |-> $past(rti_pending));
endmodule

// File: tb/sim_rti_gen.sv
module sim_rti_gen;
  localparam int BASE = 16;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam int NVEC = 4;
  // control byte written right after a tick, and the expected tick interval
  localparam logic [7:0] VEC_DATA [NVEC] = '{8'h00, 8'hFB, 8'h01, 8'hA2};
  localparam int         VEC_PER  [NVEC] = '{16, 128, 32, 64};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       pend, irq;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  rti_gen #(.BASE_PERIOD(BASE)) u0 (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .rti_pending(pend), .rti_irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic wait_flag(input int maxn, output int n);
    n = 0;
    while (!pend && n < maxn) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(pend == 1'b0, "R6 reset flag", pend, 0);
    chk(irq == 1'b0, "R6 reset irq", irq, 0);
    rst = 1'b0;

    // first tick after reset, enable still off
    wait_flag(300, n);
    chk(n == BASE, "R2 first tick", n, BASE);
    chk(irq == 1'b0, "R5 irq gated", irq, 0);
    wr(A_MASK, 8'h40);                   // edge 17
    chk(irq == 1'b0, "R7 irq lag", irq, 0);
    @(negedge clk);                      // edge 18
    chk(irq == 1'b1, "R7 irq rise", irq, 1);
    wr(A_FLAG, 8'h00);                   // edge 19
    chk(pend == 1'b1, "R4 zero write", pend, 1);
    wr(A_FLAG, 8'hBF);                   // edge 20
    chk(pend == 1'b1, "R4 other bits", pend, 1);
    wr(A_FLAG, 8'h40);                   // edge 21
    chk(pend == 1'b0, "R4 clear", pend, 0);
    chk(irq == 1'b1, "R7 irq still set", irq, 1);
    @(negedge clk);                      // edge 22
    chk(irq == 1'b0, "R7 irq fall", irq, 0);

    // table: rate write one edge after a tick, clear, measure interval
    wait_flag(300, n);
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CTRL, VEC_DATA[i]);
      chk(pend == 1'b1, "R3 write keeps flag", pend, 1);
      wr(A_FLAG, 8'h40);
      chk(pend == 1'b0, "R4 clear in table", pend, 0);
      wait_flag(300, n);
      chk(n + 2 == VEC_PER[i], "R1 R3 interval", n + 2, VEC_PER[i]);
    end

    // rescheduled tick already in the past
    wr(A_CTRL, 8'h03);                   // T+1
    wr(A_FLAG, 8'h40);                   // T+2
    repeat (38) @(negedge clk);          // T+40
    chk(pend == 1'b0, "R1 slow rate no tick", pend, 0);
    wr(A_CTRL, 8'h00);                   // T+41
    chk(pend == 1'b0, "R3 rate write no set", pend, 0);
    @(negedge clk);                      // T+42
    chk(pend == 1'b1, "R8 past tick next cycle", pend, 1);

    // clear landing on a tick edge
    repeat (15) @(negedge clk);
    wr(A_FLAG, 8'h40);                   // tick edge
    chk(pend == 1'b1, "R9 tick beats clear", pend, 1);
    wr(A_FLAG, 8'h40);
    chk(pend == 1'b0, "R4 clear after tick", pend, 0);

    // reset in the middle of a slow period
    wr(A_CTRL, 8'h03);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(pend == 1'b0 && irq == 1'b0, "R6 mid reset", {pend, irq}, 0);
    rst = 1'b0;
    wait_flag(300, n);
    chk(n == BASE, "R6 rate back to zero", n, BASE);
    @(negedge clk);
    chk(irq == 1'b0, "R6 enable cleared", irq, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule